// File: doc/BRIEF.md
# Banked Private Interrupt Priority Bank

This block holds one 8-bit priority for each of 32 private interrupts and serves them over a simple request port. An access is either a single byte or a 32-bit word. A word access covers four consecutive interrupts. The whole array is also driven out in parallel so that a priority selector can use it.

Each access carries a secure attribute. A global security-off flag and a per-interrupt group bitmap come in alongside it. When the access is non-secure and security is on, the access sees a restricted view. Group 0 entries are hidden: they read as zero and cannot be written. Group 1 entries are exposed through a half-range mapping, in which the stored value keeps its top bit set and the visible value is the stored value shifted left by one. Each lane of a word access applies these rules on its own.

A read returns its data one cycle after the request. Every write, including a write that changes nothing, raises a one-cycle update strobe so that the selector downstream can re-evaluate.

Top module: `prio_bank`

## Requirements
- R1: While reset is held and directly after it, every stored priority is 0x00, and both rvalid_o and upd_o are low.
- R2: A secure access reads and writes the stored byte unchanged, whatever the group bit.
- R3: With sec_off_i high, a non-secure access behaves exactly like a secure access.
- R4: A non-secure read (security on) of an entry whose group bit is 1 returns (stored << 1) truncated to 8 bits.
- R5: A non-secure write (security on) of an entry whose group bit is 1 stores 0x80 | (value >> 1).
- R6: A non-secure read (security on) of an entry whose group bit is 0 returns 0x00.
- R7: A non-secure write (security on) of an entry whose group bit is 0 leaves the stored value unchanged.
- R8: A word access at offset k (k a multiple of 4) covers interrupts k to k+3. Interrupt k+n sits in bits 8n+7:8n, and each byte is filtered by its own group bit.
- R9: A byte access at offset k uses bits 7:0 of the write data. It returns the entry in rdata_o[7:0], with bits 31:8 zero.
- R10: A read request with req_i high and we_i low sets rvalid_o high in the next cycle, with its data on rdata_o. rvalid_o is low in any cycle that does not follow a read request.
- R11: Every write request raises upd_o for exactly the next cycle, whether or not any value changed, including a write that R7 blocks.
- R12: prio_o carries entry j in bits 8j+7:8j and reflects a write in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 32-bit word access, 0 = byte access |
| addr_i | input | 5 | Byte offset in the priority window (interrupt number) |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Secure attribute of the access |
| sec_off_i | input | 1 | Global security-off flag |
| group_i | input | 32 | Group bit per interrupt (1 = group 1) |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| upd_o | output | 1 | One-cycle strobe after any write |
| prio_o | output | 256 | All stored priorities, entry j at bits 8j+7:8j |

## Verification
The assertions assume that word accesses use an offset that is a multiple of four. They also assume that group_i, secure_i and sec_off_i stay steady while a request is presented, since the group bit is sampled in the same cycle as the request. The stimulus keeps within these limits. It issues only aligned word offsets, including the last aligned offset 28. It changes the group bitmap and the security inputs only between requests, and each read compares against a model that has captured those inputs at the time of the request.

// File: rtl/prio_view_pkg.sv
package prio_view_pkg;
  parameter int PRIO_BITS = 8;
  typedef logic [PRIO_BITS-1:0] prio_t;

  // restricted view of a group-1 entry
  function automatic prio_t ns_read_view(prio_t stored);
    return {stored[PRIO_BITS-2:0], 1'b0};
  endfunction

  // fold a restricted-view value into the upper half range
  function automatic prio_t ns_write_fold(prio_t v);
    return {1'b1, v[PRIO_BITS-1:1]};
  endfunction
endpackage

// File: rtl/prio_lane_view.sv
module prio_lane_view
  import prio_view_pkg::*;
(
  input  prio_t stored_i,
  input  prio_t wval_i,
  input  logic  ns_view_i,
  input  logic  grp_i,
  output prio_t rd_view_o,
  output logic  wr_allow_o,
  output prio_t wr_val_o
);
  always_comb begin
    if (!ns_view_i)   rd_view_o = stored_i;
    else if (grp_i)   rd_view_o = ns_read_view(stored_i);
    else              rd_view_o = '0;
    wr_allow_o = !ns_view_i || grp_i;
    wr_val_o   = ns_view_i ? ns_write_fold(wval_i) : wval_i;
  end
endmodule

// File: rtl/prio_store.sv
module prio_store
  import prio_view_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int FLAT_W = NUM_IRQ * PRIO_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IRQ-1:0] wr_en_i,
  input  logic [FLAT_W-1:0] wr_data_i,
  output logic [FLAT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      for (int j = 0; j < NUM_IRQ; j++) begin
        if (wr_en_i[j]) q_o[j*PRIO_BITS +: PRIO_BITS] <= wr_data_i[j*PRIO_BITS +: PRIO_BITS];
      end
    end
  end
endmodule

// File: rtl/prio_bank.sv
module prio_bank
  import prio_view_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int LANES   = 4,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int BUS_W  = LANES * PRIO_BITS,
  localparam int FLAT_W = NUM_IRQ * PRIO_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               word_i,
  input  logic [IDX_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic               secure_i,
  input  logic               sec_off_i,
  input  logic [NUM_IRQ-1:0] group_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               rvalid_o,
  output logic               upd_o,
  output logic [FLAT_W-1:0]  prio_o
);
  logic              ns_view;
  logic [FLAT_W-1:0] prio_q;
  prio_t             prio_arr [NUM_IRQ];
  logic [LANES-1:0]  lane_act, lane_we;
  logic [IDX_W-1:0]  lane_idx [LANES];
  prio_t             lane_wv  [LANES];
  logic [BUS_W-1:0]  rd_word;
  logic [NUM_IRQ-1:0] wr_en;
  logic [FLAT_W-1:0] wr_data;

  assign ns_view = !secure_i && !sec_off_i;

  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_unpack
    assign prio_arr[j] = prio_q[j*PRIO_BITS +: PRIO_BITS];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W:0] idx_ext;
    logic           allow;
    prio_t          view;

    assign idx_ext     = {1'b0, addr_i} + (IDX_W+1)'(l);
    assign lane_idx[l] = idx_ext[IDX_W-1:0];
    assign lane_act[l] = req_i && (word_i || (l == 0)) && (idx_ext < (IDX_W+1)'(NUM_IRQ));

    prio_lane_view u_view (
      .stored_i   (prio_arr[lane_idx[l]]),
      .wval_i     (wdata_i[l*PRIO_BITS +: PRIO_BITS]),
      .ns_view_i  (ns_view),
      .grp_i      (group_i[lane_idx[l]]),
      .rd_view_o  (view),
      .wr_allow_o (allow),
      .wr_val_o   (lane_wv[l])
    );

    assign lane_we[l] = lane_act[l] && we_i && allow;
    assign rd_word[l*PRIO_BITS +: PRIO_BITS] = lane_act[l] ? view : '0;
  end

  // lanes address distinct entries, so no merge conflict
  always_comb begin
    wr_en   = '0;
    wr_data = prio_q;
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) begin
        wr_en[lane_idx[l]] = 1'b1;
        wr_data[lane_idx[l]*PRIO_BITS +: PRIO_BITS] = lane_wv[l];
      end
    end
  end

  prio_store #(.NUM_IRQ(NUM_IRQ)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .q_o       (prio_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      upd_o    <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      upd_o    <= req_i && we_i;
      if (req_i && !we_i) rdata_o <= rd_word;
    end
  end

  assign prio_o = prio_q;

  // checker state: entry touched by the previous request
  logic [IDX_W-1:0] chk_idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    chk_idx_q <= '0;
    else if (req_i) chk_idx_q <= addr_i;
  end

  // R11
  upd_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i |=> upd_o);
  // R11
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> !upd_o);
  // R10
  rvalid_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);
  // R10
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  // R7
  ns_group0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !word_i && !secure_i && !sec_off_i && !group_i[addr_i] |=> $stable(prio_o));
  // R6
  ns_group0_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !word_i && !secure_i && !sec_off_i && !group_i[addr_i] |=> rdata_o == '0);
  // R5
  ns_fold_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !word_i && !secure_i && !sec_off_i && group_i[addr_i]
    |=> prio_arr[chk_idx_q][PRIO_BITS-1]);
  // R9
  byte_read_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !word_i |=> rdata_o[BUS_W-1:PRIO_BITS] == '0);
  // R8
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && word_i |-> addr_i[1:0] == 2'b00);
endmodule

// File: tb/prio_bank_bench.sv
module prio_bank_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0, we_i = 1'b0, word_i = 1'b0;
  logic [4:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic         secure_i = 1'b0, sec_off_i = 1'b0;
  logic [31:0]  group_i = '0;
  logic [31:0]  rdata_o;
  logic         rvalid_o, upd_o;
  logic [255:0] prio_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] model [32];
  bit         q_rv [$];
  logic [31:0] q_rd [$];
  bit         q_up [$];
  string      q_tag [$];

  always #10 clk = ~clk;

  prio_bank u_prio_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .word_i(word_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .secure_i(secure_i), .sec_off_i(sec_off_i),
    .group_i(group_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .upd_o(upd_o),
    .prio_o(prio_o)
  );

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle, samples after the edge
  always @(posedge clk) begin
    #1;
    if (q_rv.size() > 0) begin
      bit rv, up; logic [31:0] rd; string tag;
      rv = q_rv.pop_front(); rd = q_rd.pop_front(); up = q_up.pop_front(); tag = q_tag.pop_front();
      check(rvalid_o == rv, {tag, " R10 rvalid"}, 256'(rvalid_o), 256'(rv));
      check(upd_o == up, {tag, " R11 upd"}, 256'(upd_o), 256'(up));
      if (rv) check(rdata_o == rd, {tag, " rdata"}, 256'(rdata_o), 256'(rd));
    end
  end

  // driver: one access per cycle, model from the requirements
  task automatic access(input bit we, input bit word, input int addr, input logic [31:0] wd,
                        input bit sec, input bit soff, input string tag);
    logic [31:0] exp = '0;
    bit ns = !sec && !soff;
    @(negedge clk);
    req_i = 1; we_i = we; word_i = word; addr_i = 5'(addr); wdata_i = wd;
    secure_i = sec; sec_off_i = soff;
    for (int l = 0; l < (word ? 4 : 1); l++) begin
      int idx = addr + l;
      logic [7:0] v = wd[l*8 +: 8];
      if (idx < 32) begin
        if (we) begin
          if (!ns) model[idx] = v;
          else if (group_i[idx]) model[idx] = 8'h80 | (v >> 1);
        end else begin
          if (!ns) exp[l*8 +: 8] = model[idx];
          else if (group_i[idx]) exp[l*8 +: 8] = {model[idx][6:0], 1'b0};
        end
      end
    end
    q_rv.push_back(!we); q_rd.push_back(exp); q_up.push_back(we); q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_i = 0; we_i = 0;
    q_rv.push_back(0); q_rd.push_back('0); q_up.push_back(0); q_tag.push_back(tag);
  endtask

  task automatic check_array(input string tag);
    logic [255:0] exp;
    for (int j = 0; j < 32; j++) exp[j*8 +: 8] = model[j];
    check(prio_o == exp, {tag, " R12 prio_o"}, prio_o, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 32; j++) model[j] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(prio_o == '0, "R1 prio reset", prio_o, '0);
    check(!rvalid_o && !upd_o, "R1 strobes low", 256'({rvalid_o, upd_o}), '0);
    rst_ni = 1;
    idle("R1"); idle("R1");
    check_array("R1");

    // R2 secure byte write/read, R9 byte lane
    access(1, 0, 3, 32'hFFFF_FF5A, 1, 0, "R2 wr");
    access(0, 0, 3, 0, 1, 0, "R2 R9 rd");
    idle("R2"); check_array("R2");

    // R5/R4 non-secure group 1
    group_i = 32'h0000_00F0;
    access(1, 0, 4, 32'h0000_0064, 0, 0, "R5 wr");
    idle("R5"); check_array("R5");
    access(0, 0, 4, 0, 1, 0, "R5 secure rd");
    access(0, 0, 4, 0, 0, 0, "R4 ns rd");

    // R7/R6 non-secure group 0, R11 strobe on blocked write
    access(1, 0, 3, 32'h0000_00FF, 0, 0, "R7 R11 wr");
    idle("R7"); check_array("R7");
    access(0, 0, 3, 0, 0, 0, "R6 rd");

    // R3 security off
    access(1, 0, 3, 32'h0000_0011, 0, 1, "R3 wr");
    access(0, 0, 3, 0, 0, 1, "R3 rd");
    idle("R3"); check_array("R3");

    // R8 word secure
    access(1, 1, 8, 32'h4433_2211, 1, 0, "R8 wr");
    access(0, 1, 8, 0, 1, 0, "R8 rd");
    // R8 R5 word non-secure, all group 1
    access(1, 1, 4, 32'h8040_2010, 0, 0, "R8 ns wr");
    idle("R8"); check_array("R8");
    access(0, 1, 4, 0, 0, 0, "R8 R4 ns rd");

    // R8 mixed groups per lane
    access(1, 1, 0, 32'hDDCC_BBAA, 1, 0, "R8 mix setup");
    idle("R8");
    group_i = 32'h0000_0005;
    access(0, 1, 0, 0, 0, 0, "R8 R6 mix rd");
    access(1, 1, 0, 32'h1234_5678, 0, 0, "R8 R7 mix wr");
    idle("R8"); check_array("R8 mix");
    access(0, 1, 0, 0, 1, 0, "R8 mix secure rd");

    // last aligned word, top entries
    group_i = 32'h8000_0000;
    access(1, 1, 28, 32'hF0E0_D0C0, 1, 0, "R8 top wr");
    access(0, 1, 28, 0, 0, 0, "R8 top ns rd");
    access(0, 0, 31, 0, 0, 0, "R9 top byte rd");
    idle("R11"); idle("R11"); check_array("R12 final");

    while (q_rv.size() > 0) @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule